// File: doc/BRIEF.md
# Buffered Configuration Word Mover

This block is a bus peripheral that moves a burst of 32-bit words between an internal buffer RAM, one frame deep, and a configuration port. Software reaches the buffer through the low half of a byte-addressed bus window: word N sits at byte address N×4. The upper half holds four control registers. Software loads the buffer, writes a byte count and a starting word index, and then writes a direction register. That write launches the burst. A status register tells software when the burst has finished.

Two directions are supported. In the outbound direction (configure), the buffer feeds the port and each word leaves with a one-cycle strobe, paced by the port's ready line. In the inbound direction (readback), the engine holds a read request high and stores each word that the port returns, with a valid pulse, into consecutive buffer slots. Long streams are handled as a series of bursts: software reloads or drains the buffer between them. A write to the status register aborts whatever is running.

Top module: `cfgbuf_engine`

## Requirements
- R1: After reset, status bit 0 reads 1, and `cp_wstrobe` and `cp_rreq` are low.
- R2: A bus write to byte address N×4 (N below DEPTH) stores a word that a later read of the same address returns. `bus_ack` rises in the cycle after each request, and read data is valid with it.
- R3: The byte-count register (0x800) reads back the full 32-bit value written. The start-index register (0x804) reads back only the low log2(DEPTH) bits written.
- R4: A write of bit0=0 to the direction register (0x808) sends buffer words, starting at the start index and in ascending order, out on `cp_wdata`. Each word goes with a strobe exactly one cycle long, and the burst holds floor(count/4) words.
- R5: A strobe is issued only in a cycle after one in which `cp_ready` was high. While `cp_ready` stays low, no word leaves.
- R6: A write of bit0=1 to the direction register raises `cp_rreq`. Each `cp_rvalid` word is stored at the next buffer index, beginning at the start index. `cp_rreq` falls after the last word, and valid pulses after that change nothing.
- R7: Status bit 0 reads 0 while a burst runs and 1 once it has finished.
- R8: A byte count below 4 finishes at once. Done stays 1, and no strobe or request is issued.
- R9: A burst never passes the last buffer word. It moves min(floor(count/4), DEPTH − start) words and does not wrap to index 0.
- R10: A direction write that arrives while a burst runs is ignored: the running burst goes on in its original direction.
- R11: Any write to the status register (0x80C) stops a running burst. The engine returns to idle with done=1 and `cp_rreq` low, and it sends no further strobes.
- R12: While a burst runs, bus writes to the buffer are dropped and bus reads of the buffer return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | log2(DEPTH)+3 | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Access acknowledge, one cycle after request |
| bus_rdata | output | DATA_W | Read data, valid with bus_ack |
| cp_wdata | output | DATA_W | Outbound word |
| cp_wstrobe | output | 1 | Outbound word strobe |
| cp_ready | input | 1 | Port accepts an outbound word |
| cp_rreq | output | 1 | Inbound read request |
| cp_rvalid | input | 1 | Inbound word valid |
| cp_rdata | input | DATA_W | Inbound word |

## Verification
Outbound bursts are run from a middle start index with an exact multiple of four bytes and with a byte count that has a remainder. Comparing the two separates word counting from byte counting. A stalled `cp_ready` separates pacing from free running, and a burst that starts near the top of the buffer separates clamping from wrap-around. Inbound bursts are fed extra valid words after the last expected one, to show that storing stops exactly at the count. Direction writes, buffer accesses and status writes made in mid-burst then show which bus actions the engine ignores and which it honours.

// File: rtl/cfgbuf_pkg.sv
package cfgbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SEND,
    ST_RB
  } seq_state_e;

  // register select, bus_addr[3:2] inside the register window
  localparam logic [1:0] SEL_SIZE = 2'd0;
  localparam logic [1:0] SEL_OFFS = 2'd1;
  localparam logic [1:0] SEL_DIR  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;
endpackage

// File: rtl/cfgbuf_ram.sv
module cfgbuf_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];

  // single port, synchronous read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/cfgbuf_regs.sv
module cfgbuf_regs
  import cfgbuf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  parameter int AW     = $clog2(DEPTH),
  parameter int BUS_AW = AW + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] ram_q_i,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              buf_we_o,
  output logic [AW-1:0]     buf_addr_o,
  output logic [DATA_W-3:0] size_words_o,
  output logic [AW-1:0]     offset_o,
  output logic              start_o,
  output logic              start_dir_o,
  output logic              abort_o
);
  logic [DATA_W-1:0] size_q;
  logic [AW-1:0]     offset_q;
  logic              dir_q;
  logic [DATA_W-1:0] reg_rd_q;
  logic              rd_is_buf_q;
  logic              rd_blocked_q;
  logic              is_reg;
  logic [1:0]        sel;
  logic              reg_wr;
  logic [DATA_W-1:0] reg_rd_mux;
  logic              unused_lsb;

  assign is_reg     = bus_addr[BUS_AW-1];
  assign sel        = bus_addr[3:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign reg_wr     = bus_req && bus_we && is_reg;

  assign buf_addr_o   = bus_addr[AW+1:2];
  assign buf_we_o     = bus_req && bus_we && !is_reg && !busy_i;
  assign start_o      = reg_wr && (sel == SEL_DIR) && !busy_i;
  assign start_dir_o  = bus_wdata[0];
  assign abort_o      = reg_wr && (sel == SEL_STAT);
  assign size_words_o = size_q[DATA_W-1:2];
  assign offset_o     = offset_q;

  always_comb begin
    unique case (sel)
      SEL_SIZE: reg_rd_mux = size_q;
      SEL_OFFS: reg_rd_mux = {{(DATA_W-AW){1'b0}}, offset_q};
      SEL_DIR:  reg_rd_mux = {{(DATA_W-1){1'b0}}, dir_q};
      default:  reg_rd_mux = {{(DATA_W-1){1'b0}}, done_i};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q       <= '0;
      offset_q     <= '0;
      dir_q        <= 1'b0;
      bus_ack      <= 1'b0;
      reg_rd_q     <= '0;
      rd_is_buf_q  <= 1'b0;
      rd_blocked_q <= 1'b0;
    end else begin
      bus_ack      <= bus_req;
      rd_is_buf_q  <= bus_req && !is_reg;
      rd_blocked_q <= busy_i;
      reg_rd_q     <= reg_rd_mux;
      if (reg_wr && sel == SEL_SIZE) size_q   <= bus_wdata;
      if (reg_wr && sel == SEL_OFFS) offset_q <= bus_wdata[AW-1:0];
      if (start_o)                   dir_q    <= bus_wdata[0];
    end
  end

  assign bus_rdata = rd_is_buf_q ? (rd_blocked_q ? '0 : ram_q_i) : reg_rd_q;

  assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> bus_ack);
  assert_blocked_read_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && !is_reg && busy_i) |=> (bus_rdata == '0));
endmodule

// File: rtl/cfgbuf_seq.sv
module cfgbuf_seq
  import cfgbuf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic [DATA_W-3:0] size_words_i,
  input  logic [AW-1:0]     offset_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] ram_q_i,
  input  logic              cp_ready_i,
  input  logic              cp_rvalid_i,
  input  logic [DATA_W-1:0] cp_rdata_i,
  output logic [AW-1:0]     ram_addr_o,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              cp_wstrobe_o,
  output logic [DATA_W-1:0] cp_wdata_o,
  output logic              cp_rreq_o
);
  localparam int CW = AW + 1;
  localparam int WW = DATA_W - 2;

  seq_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] rem_q;
  logic [CW-1:0] avail;
  logic [CW-1:0] count_next;

  // words that fit between the start index and the top of the buffer
  assign avail      = CW'(DEPTH) - CW'(offset_i);
  assign count_next = (size_words_i >= WW'(avail)) ? avail : size_words_i[CW-1:0];

  assign ram_addr_o  = addr_q;
  assign ram_we_o    = (state_q == ST_RB) && cp_rvalid_i && !abort_i;
  assign ram_wdata_o = cp_rdata_i;
  assign busy_o      = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      rem_q        <= '0;
      done_o       <= 1'b1;
      cp_wstrobe_o <= 1'b0;
      cp_wdata_o   <= '0;
      cp_rreq_o    <= 1'b0;
    end else begin
      cp_wstrobe_o <= 1'b0;
      if (abort_i) begin
        state_q   <= ST_IDLE;
        rem_q     <= '0;
        done_o    <= 1'b1;
        cp_rreq_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (start_i && count_next != '0) begin
              addr_q <= offset_i;
              rem_q  <= count_next;
              done_o <= 1'b0;
              if (dir_i) begin
                state_q   <= ST_RB;
                cp_rreq_o <= 1'b1;
              end else begin
                state_q <= ST_FETCH;
              end
            end
          end
          ST_FETCH: state_q <= ST_SEND;
          ST_SEND: begin
            if (cp_ready_i) begin
              cp_wstrobe_o <= 1'b1;
              cp_wdata_o   <= ram_q_i;
              addr_q       <= addr_q + 1'b1;
              rem_q        <= rem_q - 1'b1;
              if (rem_q == CW'(1)) begin
                state_q <= ST_IDLE;
                done_o  <= 1'b1;
              end else begin
                state_q <= ST_FETCH;
              end
            end
          end
          ST_RB: begin
            if (cp_rvalid_i) begin
              addr_q <= addr_q + 1'b1;
              rem_q  <= rem_q - 1'b1;
              if (rem_q == CW'(1)) begin
                state_q   <= ST_IDLE;
                done_o    <= 1'b1;
                cp_rreq_o <= 1'b0;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    cp_wstrobe_o |=> !cp_wstrobe_o);
  assert_strobe_after_ready_R5: assert property (@(posedge clk) disable iff (rst)
    cp_wstrobe_o |-> $past(cp_ready_i));
  assert_rreq_in_readback_R6: assert property (@(posedge clk) disable iff (rst)
    cp_rreq_o |-> (state_q == ST_RB));
  assert_busy_not_done_R7: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !done_o);
  assert_short_count_done_R8: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !abort_i && count_next == '0) |=> (done_o && !busy_o));
  assert_within_buffer_R9: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> ((CW+1)'(addr_q) + (CW+1)'(rem_q) <= (CW+1)'(DEPTH)));
  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (done_o && !cp_rreq_o && !busy_o));
endmodule

// File: rtl/cfgbuf_engine.sv
module cfgbuf_engine #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_req,
  input  logic                       bus_we,
  input  logic [$clog2(DEPTH)+2:0]   bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic                       bus_ack,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [DATA_W-1:0]          cp_wdata,
  output logic                       cp_wstrobe,
  input  logic                       cp_ready,
  output logic                       cp_rreq,
  input  logic                       cp_rvalid,
  input  logic [DATA_W-1:0]          cp_rdata
);
  localparam int AW     = $clog2(DEPTH);
  localparam int BUS_AW = AW + 3;

  logic              busy, done;
  logic              regs_buf_we, seq_we, ram_we;
  logic [AW-1:0]     regs_buf_addr, seq_addr, ram_addr, offset;
  logic [DATA_W-1:0] seq_wdata, ram_wdata, ram_q;
  logic [DATA_W-3:0] size_words;
  logic              start, start_dir, abort;

  // the engine owns the RAM port for the whole burst
  assign ram_addr  = busy ? seq_addr  : regs_buf_addr;
  assign ram_we    = busy ? seq_we    : regs_buf_we;
  assign ram_wdata = busy ? seq_wdata : bus_wdata;

  cfgbuf_regs #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .BUS_AW(BUS_AW)) u_regs (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy_i(busy), .done_i(done), .ram_q_i(ram_q),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .buf_we_o(regs_buf_we),
    .buf_addr_o(regs_buf_addr), .size_words_o(size_words), .offset_o(offset),
    .start_o(start), .start_dir_o(start_dir), .abort_o(abort)
  );

  cfgbuf_seq #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start_i(start), .dir_i(start_dir),
    .size_words_i(size_words), .offset_i(offset), .abort_i(abort), .ram_q_i(ram_q),
    .cp_ready_i(cp_ready), .cp_rvalid_i(cp_rvalid), .cp_rdata_i(cp_rdata),
    .ram_addr_o(seq_addr), .ram_we_o(seq_we), .ram_wdata_o(seq_wdata),
    .busy_o(busy), .done_o(done), .cp_wstrobe_o(cp_wstrobe), .cp_wdata_o(cp_wdata),
    .cp_rreq_o(cp_rreq)
  );

  cfgbuf_ram #(.WIDTH(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .q(ram_q)
  );

  assert_bus_locked_out_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_req && bus_we && !bus_addr[BUS_AW-1]) |-> !regs_buf_we);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cp_rreq);
endmodule

// File: tb/test_cfgbuf_engine.sv
module test_cfgbuf_engine;
  localparam int DW = 32;
  localparam int DEPTH = 512;
  localparam logic [11:0] A_SIZE = 12'h800, A_OFFS = 12'h804, A_DIR = 12'h808, A_STAT = 12'h80C;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_req = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata, cp_wdata, cp_rdata = '0;
  logic bus_ack, cp_wstrobe, cp_rreq, cp_ready = 0, cp_rvalid = 0;
  int ntests = 0, nfail = 0, ncap = 0;
  logic [DW-1:0] cap [0:1023];

  always #2 clk = ~clk;

  cfgbuf_engine #(.DATA_W(DW), .DEPTH(DEPTH)) i_cfgbuf_engine (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata), .cp_wdata(cp_wdata),
    .cp_wstrobe(cp_wstrobe), .cp_ready(cp_ready), .cp_rreq(cp_rreq),
    .cp_rvalid(cp_rvalid), .cp_rdata(cp_rdata));

  always @(negedge clk) if (cp_wstrobe && ncap < 1024) begin
    cap[ncap] = cp_wdata;
    ncap = ncap + 1;
  end

  function automatic logic [31:0] pat(int i);
    return 32'hC3A5_0000 ^ 32'(i * 65539);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d, output logic ack);
    @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); d = bus_rdata; ack = bus_ack; bus_req = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    logic ack;
    bus_read(a, d, ack);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 3000; k++) begin
      rd(A_STAT, s);
      if (s[0]) return;
    end
  endtask

  task automatic launch(int off, int size, bit dir);
    bus_write(A_SIZE, 32'(size));
    bus_write(A_OFFS, 32'(off));
    bus_write(A_DIR, {31'b0, dir});
  endtask

  task automatic feed(int n, logic [31:0] base);
    for (int k = 0; k < 40 && !cp_rreq; k++) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cp_rvalid = 1; cp_rdata = base + 32'(k);
    end
    @(negedge clk); cp_rvalid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] s;
    check("R1 wstrobe", {31'b0, cp_wstrobe}, 0);
    check("R1 rreq", {31'b0, cp_rreq}, 0);
    rd(A_STAT, s);
    check("R1 status", s & 1, 1);
  endtask

  task automatic t_buffer();
    logic [31:0] d; logic ack;
    bus_write(12'h000, 32'h1111_2222);
    bus_write(12'(511*4), 32'h3333_4444);
    bus_read(12'h000, d, ack);
    check("R2 word0", d, 32'h1111_2222);
    check("R2 ack", {31'b0, ack}, 1);
    bus_read(12'(511*4), d, ack);
    check("R2 word511", d, 32'h3333_4444);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_write(A_SIZE, 32'h8765_4321);
    rd(A_SIZE, d);
    check("R3 size", d, 32'h8765_4321);
    bus_write(A_OFFS, 32'hFFFF_FE05);
    rd(A_OFFS, d);
    check("R3 offset", d, 32'h0000_0005);
  endtask

  task automatic t_configure(int off, int size);
    int b = ncap, n = size / 4;
    cp_ready = 1;
    launch(off, size, 0);
    wait_idle();
    repeat (3) @(negedge clk);
    check("R4 count", 32'(ncap - b), 32'(n));
    for (int k = 0; k < n; k++) check("R4 data", cap[b+k], pat(off + k));
  endtask

  task automatic t_stall();
    int b = ncap; logic [31:0] s;
    cp_ready = 0;
    launch(50, 12, 0);
    repeat (12) @(negedge clk);
    check("R5 no strobe while not ready", 32'(ncap - b), 0);
    rd(A_STAT, s);
    check("R7 busy status", s & 1, 0);
    cp_ready = 1;
    wait_idle();
    repeat (3) @(negedge clk);
    check("R5 count after release", 32'(ncap - b), 3);
    check("R5 last word", cap[b+2], pat(52));
    rd(A_STAT, s);
    check("R7 done status", s & 1, 1);
  endtask

  task automatic t_readback();
    logic [31:0] d, s;
    launch(200, 16, 1);
    repeat (2) @(negedge clk);
    check("R6 rreq high", {31'b0, cp_rreq}, 1);
    rd(A_STAT, s);
    check("R7 busy in readback", s & 1, 0);
    feed(6, 32'hBEEF_0000);
    wait_idle();
    check("R6 rreq low", {31'b0, cp_rreq}, 0);
    for (int k = 0; k < 4; k++) begin
      rd(12'((200 + k) * 4), d);
      check("R6 stored", d, 32'hBEEF_0000 + 32'(k));
    end
    rd(12'(204 * 4), d);
    check("R6 no store past count", d, pat(204));
  endtask

  task automatic t_short();
    int b = ncap; logic [31:0] s;
    cp_ready = 1;
    launch(10, 3, 0);
    rd(A_STAT, s);
    check("R8 done at once", s & 1, 1);
    repeat (6) @(negedge clk);
    check("R8 no strobe", 32'(ncap - b), 0);
    launch(10, 0, 1);
    repeat (2) @(negedge clk);
    check("R8 no request", {31'b0, cp_rreq}, 0);
  endtask

  task automatic t_clamp();
    int b = ncap; logic [31:0] d;
    cp_ready = 1;
    launch(508, 64, 0);
    wait_idle();
    repeat (3) @(negedge clk);
    check("R9 clamped count", 32'(ncap - b), 4);
    check("R9 last word", cap[b+3], pat(511));
    launch(510, 16, 1);
    feed(4, 32'h7700_0000);
    wait_idle();
    rd(12'(511 * 4), d);
    check("R9 top word stored", d, 32'h7700_0001);
    rd(12'h000, d);
    check("R9 no wrap", d, pat(0));
  endtask

  task automatic t_busy_start();
    int b = ncap; logic [31:0] d;
    cp_ready = 1;
    launch(300, 8, 1);
    bus_write(A_DIR, 32'h0);
    repeat (6) @(negedge clk);
    check("R10 no strobe", 32'(ncap - b), 0);
    check("R10 still reading", {31'b0, cp_rreq}, 1);
    feed(2, 32'h5A00_0000);
    wait_idle();
    rd(12'(301 * 4), d);
    check("R10 readback completed", d, 32'h5A00_0001);
  endtask

  task automatic t_abort();
    int b = ncap; logic [31:0] d, s;
    cp_ready = 0;
    launch(100, 40, 0);
    bus_write(12'(100 * 4), 32'hDEAD_BEEF);
    rd(12'(100 * 4), d);
    check("R12 read while busy", d, 0);
    bus_write(A_STAT, 32'hFEFE);
    rd(A_STAT, s);
    check("R11 done after abort", s & 1, 1);
    cp_ready = 1;
    repeat (8) @(negedge clk);
    check("R11 no strobe after abort", 32'(ncap - b), 0);
    rd(12'(100 * 4), d);
    check("R12 write dropped", d, pat(100));
    launch(400, 16, 1);
    repeat (2) @(negedge clk);
    bus_write(A_STAT, 32'hFEFE);
    @(negedge clk);
    check("R11 rreq dropped", {31'b0, cp_rreq}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_buffer();
    t_regs();
    for (int i = 0; i < DEPTH; i++) bus_write(12'(i * 4), pat(i));
    t_configure(3, 20);
    t_configure(40, 10);
    t_stall();
    t_readback();
    t_short();
    t_clamp();
    t_busy_start();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule